// File: doc/BRIEF.md
# Synthesizer Control Word Serializer

This block pushes 19-bit control words into a frequency synthesizer chip over three wires: a data line, a shift clock and a commit strobe. A word is handed over on a valid/ready handshake and held inside the block. The block then sends the bits most significant first. For each bit it drives data while the shift clock is low, raises the shift clock, and holds it high for a while. The chip samples data on each rising shift clock.

After the nineteenth bit the block runs a trailer while the shift clock is still high. It clears data, then raises the strobe. It then drops the shift clock with the strobe still high, which is the edge that commits the word inside the chip, and finally drops the strobe. Every phase lasts a fixed number of system clocks set by the `PHASE_CYCLES` parameter (at least 1). A frame therefore takes (2·19 + 3)·`PHASE_CYCLES` system clocks. Between frames all three lines rest low. The block takes a new word only when it is idle.

Top module: `synser_word_serializer`

## Requirements
- R1: After reset, and whenever the block is idle, `ser_data_o`, `ser_clk_o` and `ser_stb_o` are low, `ready_o` is 1 and `busy_o` is 0. A synchronous reset during a frame returns the block to this state at once.
- R2: A word is taken only on a cycle where `valid_i` and `ready_o` are both 1. From the next cycle until the strobe has fallen, `ready_o` is 0 and `busy_o` is 1. A `valid_i` raised during that time is ignored: no word is taken and no extra frame follows.
- R3: A frame carries exactly 19 bits. The bit present on `ser_data_o` at the k-th rising edge of `ser_clk_o` is `word_i[19-k]` as it was at acceptance, so bit 18 goes first.
- R4: At every rising edge of `ser_clk_o`, `ser_data_o` has held its value for at least `PHASE_CYCLES` cycles, and it does not change in the cycle where the clock rises.
- R5: Each bit's shift clock high time is exactly `PHASE_CYCLES` cycles. The shift clock low time between two bits of a frame is exactly `PHASE_CYCLES` cycles.
- R6: After the nineteenth high phase, `ser_data_o` goes low while `ser_clk_o` stays high. `PHASE_CYCLES` cycles later `ser_stb_o` rises, with the clock high and data low.
- R7: Exactly one falling edge of `ser_clk_o` per frame occurs while `ser_stb_o` is 1. At that edge data is low and the clock has been high for 3·`PHASE_CYCLES` cycles. `ser_stb_o` falls `PHASE_CYCLES` cycles later, with the clock low.
- R8: `ser_stb_o` is 0 at every rising edge of `ser_clk_o`.
- R9: From the accepting edge to `ready_o` returning to 1, a frame takes 41·`PHASE_CYCLES` cycles.
- R10: If `valid_i` stays 1, the next word is taken on the first idle cycle. `ready_o` is then high for exactly one cycle between the two frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| word_i | input | 19 | Control word, bit 18 sent first |
| valid_i | input | 1 | Word on `word_i` is offered |
| ready_o | output | 1 | Block is idle and takes a word |
| busy_o | output | 1 | A frame is in progress |
| ser_data_o | output | 1 | Serial data line |
| ser_clk_o | output | 1 | Shift clock, chip samples on its rise |
| ser_stb_o | output | 1 | Commit strobe |

## Verification
The words tried are all ones, all zeros, a lone top bit, a lone bottom bit, two alternating patterns and typical command words. A lone top or bottom bit reveals bit-order and off-by-one errors. The all-ones word shows whether data is really cleared before the strobe. Alternating patterns catch a shifter that skips or repeats a bit. Further runs hold `valid_i` high across a frame, both while the block is busy (it must be ignored) and at the frame end (the next word must follow back to back), and reset the block mid-frame. A pin monitor measures the run length of every phase, so a wrong phase length or order shows up even when the decoded word is right.

// File: rtl/synser_pkg.sv
package synser_pkg;

    localparam int unsigned FRAME_BITS = 19;

    // Phases of one frame; each lasts PHASE_CYCLES system clocks.
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_SETUP  = 3'd1,   // data driven, shift clock low
        PH_HIGH   = 3'd2,   // shift clock high, data held
        PH_CLEAR  = 3'd3,   // data cleared, clock still high
        PH_STB_UP = 3'd4,   // strobe raised, clock still high
        PH_CLK_DN = 3'd5    // clock dropped under strobe (commit)
    } phase_e;

    typedef struct packed {
        logic data;
        logic sclk;
        logic stb;
    } wire_set_t;

    // Line levels wanted during a given phase.
    function automatic wire_set_t drive_for(phase_e ph, logic bit_val);
        wire_set_t w;
        w = '0;
        case (ph)
            PH_SETUP: w.data = bit_val;
            PH_HIGH: begin
                w.data = bit_val;
                w.sclk = 1'b1;
            end
            PH_CLEAR: w.sclk = 1'b1;
            PH_STB_UP: begin
                w.sclk = 1'b1;
                w.stb  = 1'b1;
            end
            PH_CLK_DN: w.stb = 1'b1;
            default: w = '0;
        endcase
        return w;
    endfunction

    function automatic int unsigned cnt_width(int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/synser_phase_timer.sv
module synser_phase_timer #(
    parameter int unsigned PHASE_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic expire
);
    localparam int unsigned CNT_W = synser_pkg::cnt_width(PHASE_CYCLES);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(PHASE_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST_CNT) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign expire = (cnt_q == LAST_CNT);

endmodule

// File: rtl/synser_shifter.sv
module synser_shifter #(
    parameter int unsigned WORD_W = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              shift,
    input  logic [WORD_W-1:0] word_i,
    output logic              msb_next,
    output logic              last_bit
);
    localparam int unsigned IDX_W = synser_pkg::cnt_width(WORD_W);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);

    logic [WORD_W-1:0] sh_q, sh_d;
    logic [IDX_W-1:0]  idx_q;

    always_comb begin
        sh_d = sh_q;
        if (load) begin
            sh_d = word_i;
        end else if (shift) begin
            sh_d = {sh_q[WORD_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= '0;
            idx_q <= '0;
        end else begin
            sh_q <= sh_d;
            if (load) begin
                idx_q <= '0;
            end else if (shift) begin
                idx_q <= idx_q + IDX_W'(1);
            end
        end
    end

    assign msb_next = sh_d[WORD_W-1];
    assign last_bit = (idx_q == LAST_IDX);

endmodule

// File: rtl/synser_sequencer.sv
module synser_sequencer
    import synser_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   valid_i,
    input  logic   expire_i,
    input  logic   last_bit_i,
    output phase_e state_q,
    output phase_e state_d,
    output logic   load_o,
    output logic   shift_o,
    output logic   restart_o
);
    always_comb begin
        state_d = state_q;
        load_o  = 1'b0;
        shift_o = 1'b0;
        case (state_q)
            PH_IDLE: begin
                if (valid_i) begin
                    state_d = PH_SETUP;
                    load_o  = 1'b1;
                end
            end
            PH_SETUP: if (expire_i) state_d = PH_HIGH;
            PH_HIGH: begin
                if (expire_i) begin
                    if (last_bit_i) begin
                        state_d = PH_CLEAR;
                    end else begin
                        state_d = PH_SETUP;
                        shift_o = 1'b1;
                    end
                end
            end
            PH_CLEAR:  if (expire_i) state_d = PH_STB_UP;
            PH_STB_UP: if (expire_i) state_d = PH_CLK_DN;
            PH_CLK_DN: if (expire_i) state_d = PH_IDLE;
            default:   state_d = PH_IDLE;
        endcase
    end

    assign restart_o = (state_d != state_q) || (state_q == PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/synser_word_serializer.sv
module synser_word_serializer
    import synser_pkg::*;
#(
    parameter int unsigned WORD_W       = FRAME_BITS,
    parameter int unsigned PHASE_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] word_i,
    input  logic              valid_i,
    output logic              ready_o,
    output logic              busy_o,
    output logic              ser_data_o,
    output logic              ser_clk_o,
    output logic              ser_stb_o
);
    phase_e    state_q, state_d;
    logic      load, shift, restart, expire;
    logic      msb_next, last_bit;
    wire_set_t lines_q;

    synser_sequencer u_seq (
        .clk        (clk),
        .rst        (rst),
        .valid_i    (valid_i),
        .expire_i   (expire),
        .last_bit_i (last_bit),
        .state_q    (state_q),
        .state_d    (state_d),
        .load_o     (load),
        .shift_o    (shift),
        .restart_o  (restart)
    );

    synser_phase_timer #(.PHASE_CYCLES(PHASE_CYCLES)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .expire  (expire)
    );

    synser_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .shift    (shift),
        .word_i   (word_i),
        .msb_next (msb_next),
        .last_bit (last_bit)
    );

    // Lines are registered from the next phase so they change together
    // with the phase register and never glitch at the pins.
    always_ff @(posedge clk) begin
        if (rst) begin
            lines_q <= '0;
        end else begin
            lines_q <= drive_for(state_d, msb_next);
        end
    end

    assign ser_data_o = lines_q.data;
    assign ser_clk_o  = lines_q.sclk;
    assign ser_stb_o  = lines_q.stb;
    assign ready_o    = (state_q == PH_IDLE);
    assign busy_o     = ~ready_o;

endmodule

// File: rtl/synser_checker.sv
module synser_checker (
    input logic clk,
    input logic rst,
    input logic valid_i,
    input logic ready_o,
    input logic busy_o,
    input logic ser_data_o,
    input logic ser_clk_o,
    input logic ser_stb_o
);
    AST_IDLE_LINES_LOW: assert property (@(posedge clk) disable iff (rst)
        ready_o |-> (!ser_data_o && !ser_clk_o && !ser_stb_o)); // R1

    AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (rst)
        (valid_i && ready_o) |=> (!ready_o && busy_o)); // R2

    AST_DATA_STABLE_AT_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(ser_clk_o) |-> $stable(ser_data_o)); // R4

    AST_STB_RISE_CLK_HIGH: assert property (@(posedge clk) disable iff (rst)
        $rose(ser_stb_o) |-> (ser_clk_o && !ser_data_o)); // R6

    AST_COMMIT_DATA_LOW: assert property (@(posedge clk) disable iff (rst)
        ($fell(ser_clk_o) && ser_stb_o) |-> !ser_data_o); // R7

    AST_STB_FALL_CLK_LOW: assert property (@(posedge clk) disable iff (rst)
        $fell(ser_stb_o) |-> (!ser_clk_o && ready_o)); // R7

    AST_NO_STB_AT_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(ser_clk_o) |-> !ser_stb_o); // R8

endmodule

bind synser_word_serializer synser_checker u_chk (.*);

// File: tb/synser_word_serializer_bench.sv
module synser_word_serializer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int PH         = 3;
    localparam int WB         = 19;
    localparam int FRAME_CYC  = (2 * WB + 3) * PH;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          valid = 1'b0;
    logic [WB-1:0] word = '0;
    logic          ready, busy, sdata, sclk, sstb;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    synser_word_serializer #(.WORD_W(WB), .PHASE_CYCLES(PH)) u_synser_word_serializer (
        .clk        (clk),
        .rst        (rst),
        .word_i     (word),
        .valid_i    (valid),
        .ready_o    (ready),
        .busy_o     (busy),
        .ser_data_o (sdata),
        .ser_clk_o  (sclk),
        .ser_stb_o  (sstb)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Pin monitor: decodes frames and measures phase run lengths.
    int commits = 0, rises = 0;
    int v_setup = 0, v_high = 0, v_low = 0, v_trail = 0;
    int nbits = 0, last_bits = 0;
    int age_d = 0, run_c = 0, run_s = 0;
    logic [WB-1:0] rx = '0, last_word = '0;
    logic p_d = 1'b0, p_c = 1'b0, p_s = 1'b0;

    always @(negedge clk) begin
        if (rst) begin
            p_d = 1'b0; p_c = 1'b0; p_s = 1'b0;
            age_d = 0; run_c = 0; run_s = 0;
            nbits = 0; rx = '0;
        end else begin
            if (sclk && !p_c) begin
                rises++;
                if (sstb || sdata != p_d || age_d < PH) v_setup++;
                if (nbits > 0 && run_c != PH) v_low++;
                rx = {rx[WB-2:0], sdata};
                nbits++;
            end
            if (!sclk && p_c) begin
                if (p_s) begin
                    commits++;
                    last_word = rx;
                    last_bits = nbits;
                    nbits = 0;
                    rx = '0;
                    if (run_c != 3 * PH || sdata) v_trail++;
                end else if (run_c != PH) begin
                    v_high++;
                end
            end
            if (sstb && !p_s) begin
                if (!sclk || sdata || age_d < PH || run_c != 2 * PH) v_trail++;
            end
            if (!sstb && p_s) begin
                if (sclk || run_s != 2 * PH) v_trail++;
            end
            age_d = (sdata == p_d) ? age_d + 1 : 1;
            run_c = (sclk == p_c) ? run_c + 1 : 1;
            run_s = (sstb == p_s) ? run_s + 1 : 1;
            p_d = sdata; p_c = sclk; p_s = sstb;
        end
    end

    task automatic wait_ready();
        @(negedge clk);
        while (!ready) @(negedge clk);
    endtask

    task automatic t_reset_state();
        check(!sdata && !sclk && !sstb, "R1 lines low after reset", {sdata, sclk, sstb}, 0);
        check(ready && !busy, "R1 ready/busy after reset", {ready, busy}, 2);
    endtask

    task automatic run_frame(input logic [WB-1:0] w);
        int c0 = commits, s0 = v_setup, h0 = v_high, l0 = v_low, t0 = v_trail;
        int len = 0, hs_bad = 0;
        wait_ready();
        word = w;
        valid = 1'b1;
        @(negedge clk);
        valid = 1'b0;
        word = ~w;
        while (!ready && len < 4 * FRAME_CYC) begin
            if (!busy) hs_bad++;
            len++;
            @(negedge clk);
        end
        @(negedge clk);
        check(hs_bad == 0, "R2 busy held during frame", hs_bad, 0);
        check(len == FRAME_CYC, "R9 frame length", len, FRAME_CYC);
        check(last_word == w, "R3 decoded word", int'(last_word), int'(w));
        check(last_bits == WB, "R3 bit count", last_bits, WB);
        check(commits - c0 == 1, "R7 one commit edge", commits - c0, 1);
        check(v_setup == s0, "R4 R8 setup/strobe at rise", v_setup - s0, 0);
        check(v_high == h0 && v_low == l0, "R5 phase lengths", (v_high - h0) + (v_low - l0), 0);
        check(v_trail == t0, "R6 R7 trailer order", v_trail - t0, 0);
        check(!sdata && !sclk && !sstb, "R1 idle lines after frame", {sdata, sclk, sstb}, 0);
    endtask

    task automatic t_patterns();
        run_frame(19'h7FFFF);
        run_frame(19'h00000);
        run_frame(19'h40000);
        run_frame(19'h00001);
        run_frame(19'h2AAAA);
        run_frame(19'h55555);
        run_frame(19'b0101110001000000101);
        run_frame(19'b0100100011001011001);
    endtask

    task automatic t_ignore_when_busy(input logic [WB-1:0] a, input logic [WB-1:0] b);
        int c0 = commits, r0;
        wait_ready();
        word = a;
        valid = 1'b1;
        @(negedge clk);
        valid = 1'b0;
        repeat (10) @(negedge clk);
        word = b;
        valid = 1'b1;
        repeat (20) @(negedge clk);
        check(!ready, "R2 ready low while busy with valid", ready, 0);
        valid = 1'b0;
        wait_ready();
        @(negedge clk);
        r0 = rises;
        repeat (4 * PH) @(negedge clk);
        check(last_word == a, "R2 busy-time word ignored", int'(last_word), int'(a));
        check(commits - c0 == 1 && rises == r0, "R2 no extra frame", commits - c0, 1);
        check(ready, "R2 ready returns", ready, 1);
    endtask

    task automatic t_back_to_back(input logic [WB-1:0] a, input logic [WB-1:0] b);
        int c0 = commits, gap = 0;
        logic [WB-1:0] first;
        wait_ready();
        word = a;
        valid = 1'b1;
        @(negedge clk);
        word = b;
        while (commits == c0) @(negedge clk);
        first = last_word;
        while (!ready) @(negedge clk);
        while (ready && gap < 10) begin
            gap++;
            @(negedge clk);
        end
        valid = 1'b0;
        check(gap == 1, "R10 one idle cycle between frames", gap, 1);
        check(first == a, "R10 first word", int'(first), int'(a));
        wait_ready();
        @(negedge clk);
        check(last_word == b && commits - c0 == 2, "R10 second word", int'(last_word), int'(b));
    endtask

    task automatic t_midframe_reset();
        wait_ready();
        word = 19'h7FFFF;
        valid = 1'b1;
        @(negedge clk);
        valid = 1'b0;
        repeat (PH * 9 + 1) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(!sdata && !sclk && !sstb, "R1 lines low on mid-frame reset", {sdata, sclk, sstb}, 0);
        check(ready && !busy, "R1 idle on mid-frame reset", {ready, busy}, 2);
        rst = 1'b0;
        run_frame(19'h12345);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_patterns();
        t_ignore_when_busy(19'h0F0F0, 19'h70707);
        t_back_to_back(19'h3C3C3, 19'h4B4B4);
        t_midframe_reset();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule